// File: doc/BRIEF.md
# APB Scan Streaming Bridge

This block lets a processor run a scan-test datapath from software through an APB subordinate port. A multiplexer sits in front of the datapath inputs. In pin mode the external test pins drive the data and the clock. In test mode the bridge drives them. Each stimulus word written over APB makes the bridge emit a single scan clock pulse, derived from PCLK. The bridge samples the datapath outputs when that pulse falls and keeps them for a later APB read. One scan cycle therefore costs one write followed by one read: at least four PCLK cycles.

The bridge never starts a transfer itself. A bus manager paces every shift.

Register word map:
- Offset 0x0, control: bit 0 selects test mode; bit 1 aborts the sequencer.
- Offset 0x4: stimulus.
- Offset 0x8: captured response.
- Offset 0xC, status: bit 0 means the response is valid; bit 1 means a pulse is pending.

One stimulus word covers the whole datapath width, which is at most the APB data width.

Top module: `apb_scan_bridge`

## Requirements
- R1: After reset the bridge is in pin mode, both status bits read 0, control reads 0, and the bridge holds its scan clock low.
- R2: In pin mode `scan_in` and `scan_clk` follow `gpio_scan_in` and `gpio_scan_clk`. A stimulus write completes without error, produces no pulse and leaves status at 0.
- R3: In test mode `scan_in` carries the low SCAN_W bits of the last accepted stimulus word, starting at the edge that completes the write, and ignores `gpio_scan_in`.
- R4: An accepted stimulus write (offset 0x4, test mode) sets status bit 1. `scan_clk` stays low for one PCLK cycle, then is high for exactly one PCLK cycle.
- R5: On the edge where the pulse falls, `scan_out` is stored as the response, status bit 0 is set and status bit 1 is cleared.
- R6: A read of offset 0x8 returns the stored response zero-extended and clears status bit 0. Later reads return the same value.
- R7: A stimulus write arriving while a pulse is pending is stalled with PREADY low until the pulse completes. PREADY is high at all other times.
- R8: A stimulus write while status bit 0 is set completes with PSLVERR high. It changes neither the stimulus nor the flags, and it produces no pulse.
- R9: An access whose address has bits [1:0] nonzero, or any bit above bit 3 set, completes with PSLVERR high, reads 0 and has no side effect.
- R10: A control write with bit 1 set or bit 0 clear aborts the sequencer. The scan clock goes low, both flags clear and any capture due on that edge is discarded. Control bit 1 always reads 0.
- R11: Writes to offsets 0x8 and 0xC are ignored without error. Reads of offset 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the source of the test-mode scan clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Low only while a stimulus write is stalled |
| pslverr | output | 1 | Transfer error |
| gpio_scan_in | input | SCAN_W | Pin-mode scan stimulus |
| gpio_scan_clk | input | 1 | Pin-mode scan clock |
| scan_out | input | SCAN_W | Datapath response observed by the bridge |
| scan_in | output | SCAN_W | Muxed datapath stimulus |
| scan_clk | output | 1 | Muxed datapath clock |

## Verification
Two pairs of events can land on the same PCLK edge.

The first pair is the natural fall of a pulse and a control write that aborts it. To provoke it, an abort is issued right after a stimulus write, so that its access phase completes on the capture edge. It passes when status reads 0 and the response register still holds the earlier value.

The second pair is the release of a stalled stimulus write and the setting of response-valid. A second stimulus write directly follows the first. It must see exactly one wait state and then an error, with the stimulus unchanged.

// File: rtl/apb_scan_pkg.sv
package apb_scan_pkg;

    // Word index taken from paddr[3:2]
    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_STIM = 2'd1;
    localparam logic [1:0] IDX_RESP = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;

    // Bit positions inside control and status words
    localparam int unsigned CTRL_MODE_BIT = 0;
    localparam int unsigned CTRL_CLR_BIT  = 1;
    localparam int unsigned STAT_VLD_BIT  = 0;
    localparam int unsigned STAT_PEND_BIT = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ARM  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_e;

    typedef struct packed {
        logic       valid;
        logic       write;
        logic       bad;
        logic [1:0] idx;
    } acc_t;

endpackage

// File: rtl/apb_scan_decode.sv
module apb_scan_decode
    import apb_scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    output acc_t              acc_o
);

    localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'(15);

    always_comb begin
        acc_o.valid = psel_i && penable_i;
        acc_o.write = pwrite_i;
        acc_o.idx   = paddr_i[3:2];
        acc_o.bad   = (|paddr_i[1:0]) || (|(paddr_i & HI_MASK));
    end

endmodule

// File: rtl/apb_scan_core.sv
module apb_scan_core
    import apb_scan_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SCAN_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  acc_t              acc_i,
    input  logic [DATA_W-1:0] pwdata_i,
    input  logic [SCAN_W-1:0] scan_out_i,
    output logic [DATA_W-1:0] prdata_o,
    output logic              pready_o,
    output logic              pslverr_o,
    output logic              mode_o,
    output logic              pend_o,
    output logic              rvalid_o,
    output logic              tck_o,
    output logic [SCAN_W-1:0] stim_o
);

    typedef struct packed {
        logic              mode;
        logic              pend;
        logic              rvalid;
        logic              tck;
        seq_e              phase;
        logic [SCAN_W-1:0] stim;
        logic [SCAN_W-1:0] resp;
    } state_t;

    state_t st_d, st_q;
    logic   stall_w;
    logic   fire_w;
    logic   unused_hi;

    assign unused_hi = ^pwdata_i;

    always_comb begin
        st_d      = st_q;
        prdata_o  = '0;
        pslverr_o = 1'b0;
        stall_w   = acc_i.valid && acc_i.write && !acc_i.bad &&
                    (acc_i.idx == IDX_STIM) && st_q.mode && st_q.pend;
        pready_o  = !stall_w;
        fire_w    = acc_i.valid && !stall_w;

        // Pulse sequencer: low gap, high cycle, capture on the fall
        case (st_q.phase)
            SEQ_ARM: begin
                st_d.tck   = 1'b1;
                st_d.phase = SEQ_HIGH;
            end
            SEQ_HIGH: begin
                st_d.tck    = 1'b0;
                st_d.resp   = scan_out_i;
                st_d.rvalid = 1'b1;
                st_d.pend   = 1'b0;
                st_d.phase  = SEQ_IDLE;
            end
            default: ;
        endcase

        if (fire_w) begin
            if (acc_i.bad) begin
                pslverr_o = 1'b1;
            end else if (acc_i.write) begin
                case (acc_i.idx)
                    IDX_CTRL: begin
                        st_d.mode = pwdata_i[CTRL_MODE_BIT];
                        if (pwdata_i[CTRL_CLR_BIT] || !pwdata_i[CTRL_MODE_BIT]) begin
                            st_d.phase  = SEQ_IDLE;
                            st_d.tck    = 1'b0;
                            st_d.pend   = 1'b0;
                            st_d.rvalid = 1'b0;
                            st_d.resp   = st_q.resp;
                        end
                    end
                    IDX_STIM: begin
                        if (st_q.mode) begin
                            if (st_q.rvalid) begin
                                pslverr_o = 1'b1;
                            end else begin
                                st_d.stim  = pwdata_i[SCAN_W-1:0];
                                st_d.pend  = 1'b1;
                                st_d.phase = SEQ_ARM;
                            end
                        end
                    end
                    default: ;
                endcase
            end else begin
                case (acc_i.idx)
                    IDX_CTRL: prdata_o[CTRL_MODE_BIT] = st_q.mode;
                    IDX_RESP: begin
                        prdata_o[SCAN_W-1:0] = st_q.resp;
                        if (st_q.rvalid) st_d.rvalid = 1'b0;
                    end
                    IDX_STAT: begin
                        prdata_o[STAT_VLD_BIT]  = st_q.rvalid;
                        prdata_o[STAT_PEND_BIT] = st_q.pend;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign pend_o   = st_q.pend;
    assign rvalid_o = st_q.rvalid;
    assign tck_o    = st_q.tck;
    assign stim_o   = st_q.stim;

endmodule

// File: rtl/apb_scan_mux.sv
module apb_scan_mux #(
    parameter int unsigned SCAN_W = 8
) (
    input  logic              mode_i,
    input  logic [SCAN_W-1:0] stim_i,
    input  logic              tck_i,
    input  logic [SCAN_W-1:0] gpio_in_i,
    input  logic              gpio_clk_i,
    output logic [SCAN_W-1:0] scan_in_o,
    output logic              scan_clk_o
);

    for (genvar b = 0; b < SCAN_W; b++) begin : g_lane
        assign scan_in_o[b] = mode_i ? stim_i[b] : gpio_in_i[b];
    end

    assign scan_clk_o = mode_i ? tck_i : gpio_clk_i;

endmodule

// File: rtl/apb_scan_bridge.sv
module apb_scan_bridge
    import apb_scan_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SCAN_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [SCAN_W-1:0] gpio_scan_in,
    input  logic              gpio_scan_clk,
    input  logic [SCAN_W-1:0] scan_out,
    output logic [SCAN_W-1:0] scan_in,
    output logic              scan_clk
);

    acc_t              acc_w;
    logic              mode_w;
    logic              pend_w;
    logic              rvalid_w;
    logic              tck_w;
    logic [SCAN_W-1:0] stim_w;

    apb_scan_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel_i    (psel),
        .penable_i (penable),
        .pwrite_i  (pwrite),
        .paddr_i   (paddr),
        .acc_o     (acc_w)
    );

    apb_scan_core #(.DATA_W(DATA_W), .SCAN_W(SCAN_W)) u_core (
        .clk_i      (pclk),
        .rst_ni     (presetn),
        .acc_i      (acc_w),
        .pwdata_i   (pwdata),
        .scan_out_i (scan_out),
        .prdata_o   (prdata),
        .pready_o   (pready),
        .pslverr_o  (pslverr),
        .mode_o     (mode_w),
        .pend_o     (pend_w),
        .rvalid_o   (rvalid_w),
        .tck_o      (tck_w),
        .stim_o     (stim_w)
    );

    apb_scan_mux #(.SCAN_W(SCAN_W)) u_mux (
        .mode_i     (mode_w),
        .stim_i     (stim_w),
        .tck_i      (tck_w),
        .gpio_in_i  (gpio_scan_in),
        .gpio_clk_i (gpio_scan_clk),
        .scan_in_o  (scan_in),
        .scan_clk_o (scan_clk)
    );

endmodule

// File: rtl/apb_scan_checker.sv
module apb_scan_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SCAN_W = 8
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic              pready,
    input logic              pslverr,
    input logic              mode,
    input logic              pend,
    input logic              rvalid,
    input logic              tck,
    input logic [SCAN_W-1:0] stim
);

    assert_pulse_one_cycle_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (mode && tck) |=> !tck);

    assert_valid_after_fall_R5: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(rvalid) |-> $past(tck));

    assert_pin_mode_no_pulse_R2: assert property (@(posedge pclk) disable iff (!presetn)
        !mode |-> !tck);

    assert_stall_while_pending_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pwrite && paddr == ADDR_W'(4) && mode && pend) |-> !pready);

    assert_err_in_access_R9: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (psel && penable && pready));

    assert_err_keeps_state_R8: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pready && pslverr) |=> ($stable(stim) && $stable(mode)));

    assert_abort_clears_R10: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && pready && pwrite && paddr == ADDR_W'(0) &&
         (pwdata[1] || !pwdata[0])) |=> (!pend && !rvalid && !tck));

endmodule

bind apb_scan_bridge apb_scan_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCAN_W(SCAN_W)
) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pready  (pready),
    .pslverr (pslverr),
    .mode    (mode_w),
    .pend    (pend_w),
    .rvalid  (rvalid_w),
    .tck     (tck_w),
    .stim    (stim_w)
);

// File: tb/tb_apb_scan_bridge.sv
`timescale 1ns/1ps
module tb_apb_scan_bridge;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  gpio_scan_in = '0;
    logic        gpio_scan_clk = 1'b0;
    logic [7:0]  scan_out;
    logic [7:0]  scan_in;
    logic        scan_clk;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] rdat;
    logic        rerr;
    int          rwait;

    // Stimulus in the high byte, expected response (stimulus ^ 8'h5A) in the low byte
    localparam logic [15:0] VECS [6] = '{16'h005A, 16'hFFA5, 16'h3C66,
                                         16'hA5FF, 16'h015B, 16'h80DA};

    always #2 pclk = ~pclk;

    // Scan datapath model: one stage, loads stimulus ^ 5A on each scan clock rise
    logic [7:0] dp_q = '0;
    always @(posedge scan_clk) dp_q <= scan_in ^ 8'h5A;
    assign scan_out = dp_q;

    apb_scan_bridge dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .gpio_scan_in(gpio_scan_in),
        .gpio_scan_clk(gpio_scan_clk), .scan_out(scan_out), .scan_in(scan_in),
        .scan_clk(scan_clk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at a negedge
    task automatic apb(input logic wr, input logic [3:0] a, input logic [31:0] d);
        rwait = 0;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1'b1; #1;
        while (!pready) begin
            rwait++;
            @(negedge pclk); #1;
        end
        rdat = prdata; rerr = pslverr;
        @(negedge pclk); psel = 1'b0; penable = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        chk("R1 clock low in reset", {31'd0, scan_clk}, 32'd0);
        presetn = 1'b1;
        @(negedge pclk);
        apb(1'b0, 4'hC, 0); chk("R1 status after reset", rdat, 32'd0);
        apb(1'b0, 4'h0, 0); chk("R1 ctrl after reset", rdat, 32'd0);

        // R2 pin mode
        gpio_scan_in = 8'hC3; gpio_scan_clk = 1'b1; #1;
        chk("R2 pin data", {24'd0, scan_in}, 32'h0000_00C3);
        chk("R2 pin clock", {31'd0, scan_clk}, 32'd1);
        @(negedge pclk); gpio_scan_clk = 1'b0;
        apb(1'b1, 4'h4, 32'h11); chk("R2 stim write no error", {31'd0, rerr}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            chk("R2 no pulse", {31'd0, scan_clk}, 32'd0);
            @(negedge pclk);
        end
        apb(1'b0, 4'hC, 0); chk("R2 status stays 0", rdat, 32'd0);

        // Enter test mode
        apb(1'b1, 4'h0, 32'h1);
        apb(1'b0, 4'h0, 0); chk("R10 ctrl readback", rdat, 32'd1);
        gpio_scan_in = 8'hFF;

        // Vector walk
        for (int i = 0; i < 6; i++) begin
            apb(1'b1, 4'h4, 32'hABCD_0000 | {24'd0, VECS[i][15:8]});
            chk("R3 scan_in is stimulus", {24'd0, scan_in}, {24'd0, VECS[i][15:8]});
            chk("R4 low gap", {31'd0, scan_clk}, 32'd0);
            @(negedge pclk);
            chk("R4 high cycle", {31'd0, scan_clk}, 32'd1);
            @(negedge pclk);
            chk("R4 falls after one cycle", {31'd0, scan_clk}, 32'd0);
            apb(1'b0, 4'hC, 0); chk("R5 status valid", rdat, 32'd1);
            apb(1'b0, 4'h8, 0); chk("R6 response", rdat, {24'd0, VECS[i][7:0]});
            apb(1'b0, 4'hC, 0); chk("R6 valid cleared", rdat, 32'd0);
        end

        // R4 pending visible during the pulse
        apb(1'b1, 4'h4, 32'h33);
        apb(1'b0, 4'hC, 0); chk("R4 pending set", rdat, 32'd2);
        apb(1'b0, 4'hC, 0); chk("R5 pending cleared, valid set", rdat, 32'd1);
        apb(1'b0, 4'h8, 0); chk("R6 response 33", rdat, 32'h69);
        apb(1'b0, 4'h8, 0); chk("R6 reread same value", rdat, 32'h69);
        apb(1'b0, 4'hC, 0); chk("R6 valid stays 0", rdat, 32'd0);

        // R7 stall then R8 error on unread response
        apb(1'b1, 4'h4, 32'h42);
        apb(1'b1, 4'h4, 32'h99);
        chk("R7 one wait state", rwait, 32'd1);
        chk("R8 error on unread response", {31'd0, rerr}, 32'd1);
        chk("R8 stimulus kept", {24'd0, scan_in}, 32'h42);
        for (int k = 0; k < 3; k++) begin
            chk("R8 no extra pulse", {31'd0, scan_clk}, 32'd0);
            @(negedge pclk);
        end
        apb(1'b0, 4'h8, 0); chk("R8 response of first word", rdat, 32'h18);

        // R10 abort on the capture edge
        apb(1'b1, 4'h4, 32'h0F);
        apb(1'b1, 4'h0, 32'h3);
        chk("R10 abort no error", {31'd0, rerr}, 32'd0);
        chk("R10 clock low", {31'd0, scan_clk}, 32'd0);
        apb(1'b0, 4'hC, 0); chk("R10 flags clear", rdat, 32'd0);
        apb(1'b0, 4'h8, 0); chk("R10 capture discarded", rdat, 32'h18);
        apb(1'b0, 4'h0, 0); chk("R10 clear bit reads 0", rdat, 32'd1);

        // R10 leaving test mode aborts
        apb(1'b1, 4'h4, 32'h20);
        apb(1'b1, 4'h0, 32'h0);
        apb(1'b0, 4'hC, 0); chk("R10 exit clears flags", rdat, 32'd0);
        chk("R2 pins back in control", {24'd0, scan_in}, 32'hFF);
        apb(1'b1, 4'h0, 32'h1);

        // R9 unmapped
        apb(1'b1, 4'h6, 32'h0); chk("R9 write error", {31'd0, rerr}, 32'd1);
        apb(1'b0, 4'h0, 0); chk("R9 ctrl untouched", rdat, 32'd1);
        apb(1'b0, 4'h1, 0); chk("R9 read error", {31'd0, rerr}, 32'd1);
        chk("R9 read data 0", rdat, 32'd0);

        // R11 ignored offsets
        apb(1'b1, 4'h8, 32'h77); chk("R11 resp write no error", {31'd0, rerr}, 32'd0);
        apb(1'b0, 4'h8, 0); chk("R11 resp unchanged", rdat, 32'h18);
        apb(1'b0, 4'h4, 0); chk("R11 stim reads 0", rdat, 32'd0);
        apb(1'b1, 4'hC, 32'hFFFF); chk("R11 stat write no error", {31'd0, rerr}, 32'd0);
        apb(1'b0, 4'hC, 0); chk("R11 status unchanged", rdat, 32'd0);

        // R1 reset during a pulse
        apb(1'b1, 4'h4, 32'h55);
        presetn = 1'b0; #1;
        chk("R1 reset forces pin mode", {24'd0, scan_in}, 32'hFF);
        chk("R1 reset clock low", {31'd0, scan_clk}, 32'd0);
        @(negedge pclk); presetn = 1'b1; @(negedge pclk);
        apb(1'b0, 4'hC, 0); chk("R1 status after re-reset", rdat, 32'd0);
        apb(1'b0, 4'h0, 0); chk("R1 ctrl after re-reset", rdat, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule